// File: doc/BRIEF.md
# Power-Mode Clock Divider Controller

This block sets the CPU clock rate of a small microcontroller and manages its two low-power states. A three-bit speed field either keeps the CPU and the other bus masters at the full base rate or slows them to the base clock divided by 2, 4, 8, 16 or 32. The slowdown is delivered as a clock-enable pulse, and the divided enable feeds every bus master, including a data-transfer controller. Peripherals that are not bus masters get a separate enable that stays at full rate.

A new speed setting takes effect only at the end of the current bus cycle, which is signalled by a strobe. A sleep request enters either sleep or software standby, depending on a standby-select bit. Sleep ends on any interrupt. Standby ends only on an external interrupt. On waking, the CPU resumes at the divisor that was in force before the sleep request.

Top module: `pmclk_ctrl`

## Requirements
- R1: After reset the block is in high-speed mode with the standby bit cleared. cpu_ce and per_ce are both 1 on every cycle, and mode_high is 1.
- R2: The applied speed code sets the cpu_ce period N: 000 gives N=1, 001 gives 2, 010 gives 4, 011 gives 8, 100 gives 16, and 101, 110 and 111 all give 32. When N>1, cpu_ce is a pulse one cycle wide.
- R3: A code written through spd_wr_en/spd_wr_data is applied only at a rising edge where bus_end is 1 and the block is running. The strobe must come at least one cycle after the write edge. Until then the previous period continues unchanged.
- R4: Writing 000 returns the block to full rate (cpu_ce on every cycle, mode_high=1) only at the next bus_end.
- R5: When a changed code is applied at an edge, the divider restarts. The first cpu_ce then comes in the Nth cycle after that edge.
- R6: per_ce is 1 in high-speed, medium-speed and sleep mode.
- R7: A sleep_req pulse while running with the standby bit 0 enters sleep mode: mode_sleep=1, cpu_ce=0 and per_ce=1.
- R8: A sleep_req pulse while running with the standby bit 1 enters software standby: mode_stby=1, with cpu_ce=0 and per_ce=0.
- R9: Sleep mode ends on irq_any or irq_ext. Standby ignores irq_any and ends only on irq_ext.
- R10: Waking restores the divisor that was applied before the sleep request. The divider restarts, so the first cpu_ce comes in the Nth cycle after the wake edge.
- R11: Exactly one of mode_high, mode_med, mode_sleep and mode_stby is 1 at all times. mode_med means running with a non-zero applied code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd_wr_en | input | 1 | Write strobe for the speed field |
| spd_wr_data | input | 3 | Speed code to store |
| sby_wr_en | input | 1 | Write strobe for the standby-select bit |
| sby_wr_data | input | 1 | Standby-select value |
| bus_end | input | 1 | Current bus cycle ends this cycle |
| sleep_req | input | 1 | Sleep instruction executed |
| irq_any | input | 1 | Any interrupt request |
| irq_ext | input | 1 | External interrupt request |
| cpu_ce | output | 1 | Clock enable for the CPU and bus masters |
| per_ce | output | 1 | Full-rate clock enable for peripherals |
| mode_high | output | 1 | Running at full rate |
| mode_med | output | 1 | Running at a divided rate |
| mode_sleep | output | 1 | In sleep mode |
| mode_stby | output | 1 | In software standby |

## Verification
The assertions check several properties on every cycle. The mode flags stay one-hot. The applied code changes only after a bus-cycle-end strobe. The enables follow the rules for sleep and standby. Standby never exits without an external interrupt. A medium-speed pulse never lasts two cycles. The bench scenarios cover what a single-cycle property cannot show: the exact pulse period for each code, the delay from a switch or wake to the first enable, the deferral of a written code until the strobe, and the divisor restored after each wake path.

// File: rtl/pmclk_ctrl.sv
module pmclk_ctrl #(
  parameter int MAX_SH = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spd_wr_en,
  input  logic [2:0] spd_wr_data,
  input  logic       sby_wr_en,
  input  logic       sby_wr_data,
  input  logic       bus_end,
  input  logic       sleep_req,
  input  logic       irq_any,
  input  logic       irq_ext,
  output logic       cpu_ce,
  output logic       per_ce,
  output logic       mode_high,
  output logic       mode_med,
  output logic       mode_sleep,
  output logic       mode_stby
);
  localparam int CNT_W = MAX_SH;

  typedef enum logic [1:0] {PM_RUN, PM_SLEEP, PM_STBY} pm_t;

  pm_t              pm_q;
  logic [2:0]       spd_q, act_q;
  logic             sby_q;
  logic [CNT_W-1:0] cnt_q, lim;
  logic [2:0]       sh;
  logic             tick, running;

  assign sh      = (act_q > 3'(MAX_SH)) ? 3'(MAX_SH) : act_q;
  assign lim     = CNT_W'((32'd1 << sh) - 32'd1);
  assign tick    = (cnt_q == lim);
  assign running = (pm_q == PM_RUN);

  assign cpu_ce     = running && tick;
  assign per_ce     = (pm_q != PM_STBY);
  assign mode_high  = running && (act_q == 3'd0);
  assign mode_med   = running && (act_q != 3'd0);
  assign mode_sleep = (pm_q == PM_SLEEP);
  assign mode_stby  = (pm_q == PM_STBY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm_q  <= PM_RUN;
      spd_q <= 3'd0;
      act_q <= 3'd0;
      sby_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (spd_wr_en) spd_q <= spd_wr_data;
      if (sby_wr_en) sby_q <= sby_wr_data;
      unique case (pm_q)
        PM_RUN: begin
          if (sleep_req) begin
            pm_q <= sby_q ? PM_STBY : PM_SLEEP;
          end else if (bus_end && spd_q != act_q) begin
            act_q <= spd_q;
            cnt_q <= '0;
          end else begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
          end
        end
        PM_SLEEP: if (irq_any || irq_ext) begin
          pm_q  <= PM_RUN;
          cnt_q <= '0;
        end
        PM_STBY: if (irq_ext) begin
          pm_q  <= PM_RUN;
          cnt_q <= '0;
        end
        default: pm_q <= PM_RUN;
      endcase
    end
  end

  a_r11_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mode_high, mode_med, mode_sleep, mode_stby}) == 1);

  a_r3_apply_on_bus_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(bus_end));

  a_r7_sleep_enables: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sleep |-> (!cpu_ce && per_ce));

  a_r8_stby_enables: assert property (@(posedge clk) disable iff (!rst_n)
    mode_stby |-> (!cpu_ce && !per_ce));

  a_r9_stby_exit_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_stby) |-> $past(irq_ext));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && mode_med && !bus_end) |=> !cpu_ce);

  a_r6_per_running: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_high || mode_med || mode_sleep) |-> per_ce);
endmodule

// File: tb/tb_pmclk_ctrl.sv
module tb_pmclk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int VEC [NVEC][2] = '{'{1,2}, '{2,4}, '{3,8}, '{4,16},
                                   '{5,32}, '{6,32}, '{7,32}, '{0,1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic spd_wr_en = 0, sby_wr_en = 0, sby_wr_data = 0;
  logic [2:0] spd_wr_data = 0;
  logic bus_end = 0, sleep_req = 0, irq_any = 0, irq_ext = 0;
  logic cpu_ce, per_ce, mode_high, mode_med, mode_sleep, mode_stby;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmclk_ctrl dut (.clk, .rst_n, .spd_wr_en, .spd_wr_data, .sby_wr_en,
    .sby_wr_data, .bus_end, .sleep_req, .irq_any, .irq_ext, .cpu_ce,
    .per_ce, .mode_high, .mode_med, .mode_sleep, .mode_stby);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ce(output int k);
    k = 1;
    while (!cpu_ce && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wr_spd(input logic [2:0] c);
    spd_wr_en = 1; spd_wr_data = c;
    @(negedge clk); spd_wr_en = 0;
  endtask

  task automatic wr_sby(input logic b);
    sby_wr_en = 1; sby_wr_data = b;
    @(negedge clk); sby_wr_en = 0;
  endtask

  task automatic pulse_bus_end;
    bus_end = 1; @(negedge clk); bus_end = 0;
  endtask

  task automatic pulse_sleep;
    sleep_req = 1; @(negedge clk); sleep_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f, g, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode_high", mode_high, 1);
    chk("R1 cpu_ce", cpu_ce, 1);
    chk("R1 per_ce", per_ce, 1);

    for (int i = 0; i < NVEC; i++) begin
      wr_spd(3'(VEC[i][0]));
      pulse_bus_end;
      wait_ce(f);
      chk($sformatf("R5 first ce code %0d", VEC[i][0]), f, VEC[i][1]);
      @(negedge clk);
      if (VEC[i][1] > 1) chk("R2 single-cycle pulse", cpu_ce, 0);
      wait_ce(g);
      if (VEC[i][1] == 1) g = 1;
      chk($sformatf("R2 period code %0d", VEC[i][0]), g, VEC[i][1]);
      chk("R11 mode_med", mode_med, VEC[i][1] > 1);
      chk("R6 per_ce", per_ce, 1);
    end
    chk("R4 back to full rate", mode_high, 1);

    pulse_sleep;
    chk("R1 standby bit clear: sleep", mode_sleep, 1);
    irq_any = 1; @(negedge clk); irq_any = 0;
    chk("R10 wake to high", cpu_ce, 1);

    wr_spd(3'd2); pulse_bus_end;
    wr_spd(3'd1);
    repeat (3) @(negedge clk);
    wait_ce(f); @(negedge clk); wait_ce(g);
    chk("R3 old period kept", g, 4);
    wait_ce(f); @(negedge clk); wait_ce(g);
    chk("R3 old period kept again", g, 4);
    pulse_bus_end;
    wait_ce(f);
    chk("R3 applied at bus_end", f, 2);

    wr_spd(3'd0);
    repeat (5) @(negedge clk);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      n += cpu_ce;
      @(negedge clk);
    end
    chk("R4 deferred high", n, 4);
    pulse_bus_end;
    chk("R4 high after bus_end", mode_high, 1);

    wr_spd(3'd3); pulse_bus_end;
    wr_sby(1'b0);
    pulse_sleep;
    chk("R7 mode_sleep", mode_sleep, 1);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      n += cpu_ce;
      @(negedge clk);
    end
    chk("R7 cpu_ce held", n, 0);
    chk("R6 per_ce in sleep", per_ce, 1);
    irq_any = 1; @(negedge clk); irq_any = 0;
    wait_ce(f);
    chk("R10 sleep wake restores /8", f, 8);
    chk("R10 mode_med after wake", mode_med, 1);

    pulse_sleep;
    irq_ext = 1; @(negedge clk); irq_ext = 0;
    chk("R9 sleep exits on irq_ext", mode_med, 1);

    wr_sby(1'b1);
    pulse_sleep;
    chk("R8 mode_stby", mode_stby, 1);
    chk("R8 per_ce low", per_ce, 0);
    chk("R8 cpu_ce low", cpu_ce, 0);
    irq_any = 1; @(negedge clk); irq_any = 0;
    repeat (4) @(negedge clk);
    chk("R9 irq_any ignored in standby", mode_stby, 1);
    chk("R9 per_ce still low", per_ce, 0);
    irq_ext = 1; @(negedge clk); irq_ext = 0;
    wait_ce(f);
    chk("R10 standby wake restores /8", f, 8);
    chk("R11 flags after wake", {mode_high, mode_med, mode_sleep, mode_stby}, 4'b0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule